// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block moves data between a working SRAM array and a shadow nonvolatile array. A command detector elsewhere hands it one-cycle store and recall requests. An external comparator supplies a supply-good level. A store first erases the shadow array and then programs it from the SRAM. A recall first clears the SRAM and then copies the shadow array into it, and it leaves the shadow contents unchanged.

While a transfer runs, the block raises busy. During that time it keeps the data outputs in high impedance and ignores every host read and write. After reset the block waits for supply-good. When supply-good rises it runs a recall on its own, and the SRAM is not available until that recall ends. Low supply prevents a store from starting and aborts a store that is already running. A recall always runs to its end. Each phase lasts a parameterised number of clock ticks. Both arrays sit inside the block as plain registers, with a synchronous host port.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset the block is busy and serves no host access. When supply_ok is first seen high, a recall starts. The block returns to idle after RCL_CLEAR_TICKS + RCL_COPY_TICKS cycles.
- R2: A recall first clears every SRAM word to zero and then copies every shadow word into the SRAM. The shadow array is not changed.
- R3: A store first erases every shadow word to all ones and then copies every SRAM word into the shadow array. The SRAM is not changed.
- R4: A store request that arrives while supply_ok is low is dropped. If supply_ok is low during a running store, the block goes to idle and pulses store_aborted for exactly one cycle. The SRAM is untouched. The shadow array is unchanged if the abort comes in the erase phase, and all ones if it comes in the program phase.
- R5: A recall is not affected by supply_ok and always completes.
- R6: busy rises combinationally in the cycle a request is accepted. Requests that arrive while busy are dropped. When both requests arrive in the same idle cycle, the recall wins.
- R7: While busy, host writes change nothing, host reads do not update rdata, and dq_oe is low.
- R8: standby is high exactly when ce_n is high and no transfer is running or being accepted.
- R9: When idle, a cycle with ce_n low and we_n high loads the SRAM word at addr into rdata at the next clock edge. dq_oe is high exactly when the block is idle, ce_n is low, oe_n is low and we_n is high.
- R10: When idle, a cycle with ce_n low and we_n low writes wdata into the SRAM word at addr.
- R11: A store keeps busy high for STO_ERASE_TICKS + STO_PROG_TICKS clock edges after the accepting edge. A recall keeps busy high for RCL_CLEAR_TICKS + RCL_COPY_TICKS clock edges after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above the sense threshold |
| store_req | input | 1 | Store request pulse from the command detector |
| recall_req | input | 1 | Recall request pulse from the command detector |
| ce_n | input | 1 | Host chip select, active low |
| we_n | input | 1 | Host write strobe, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | $clog2(DEPTH) | Host word address |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered host read data |
| dq_oe | output | 1 | Data output driver enable (low means high impedance) |
| busy | output | 1 | Transfer running or being accepted |
| standby | output | 1 | Deselected with no transfer running |
| store_aborted | output | 1 | One-cycle pulse when a store is cut off by low supply |

## Verification
The assertions assume that store and recall requests come from a detector that is synchronous to clk. They also assume that supply_ok is already synchronised, so it can change on any clock but never between edges. The checks on the phase counter and the abort pulse also assume that every tick parameter is at least one. The stimulus changes all inputs only on the falling edge. It holds request pulses for one cycle. It drops supply_ok at chosen points inside the erase phase, inside the program phase and across a whole recall, so every abort window is reached without leaving those assumptions.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

   typedef enum logic [2:0] {
      PH_OFF   = 3'd0,
      PH_IDLE  = 3'd1,
      PH_ERASE = 3'd2,
      PH_PROG  = 3'd3,
      PH_CLEAR = 3'd4,
      PH_COPY  = 3'd5
   } phase_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // counts down one step per edge unless reloaded
   p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nv_phase_fsm.sv
module nv_phase_fsm
   import nv_seq_pkg::*;
#(
   parameter int CW              = 8,
   parameter int STO_ERASE_TICKS = 4,
   parameter int STO_PROG_TICKS  = 4,
   parameter int RCL_CLEAR_TICKS = 2,
   parameter int RCL_COPY_TICKS  = 2,
   parameter bit RECALL_FIRST    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          supply_ok,
   input  logic          store_req,
   input  logic          recall_req,
   input  logic          tmr_done,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          op_erase,
   output logic          op_prog,
   output logic          op_clear,
   output logic          op_copy,
   output logic          busy,
   output logic          store_aborted,
   output phase_t        phase
);

   localparam logic [CW-1:0] ERASE_LD = CW'(STO_ERASE_TICKS - 1);
   localparam logic [CW-1:0] PROG_LD  = CW'(STO_PROG_TICKS - 1);
   localparam logic [CW-1:0] CLEAR_LD = CW'(RCL_CLEAR_TICKS - 1);
   localparam logic [CW-1:0] COPY_LD  = CW'(RCL_COPY_TICKS - 1);

   phase_t phase_nx;
   logic   idle, take_rcl, take_sto, abort_nx;

   assign idle = (phase == PH_IDLE);

   generate
      if (RECALL_FIRST) begin : g_rcl_first
         assign take_rcl = idle & recall_req;
         assign take_sto = idle & store_req & supply_ok & ~recall_req;
      end else begin : g_sto_first
         assign take_sto = idle & store_req & supply_ok;
         assign take_rcl = idle & recall_req & ~(store_req & supply_ok);
      end
   endgenerate

   always_comb begin
      phase_nx = phase;
      tmr_load = 1'b0;
      tmr_val  = '0;
      op_erase = 1'b0;
      op_prog  = 1'b0;
      op_clear = 1'b0;
      op_copy  = 1'b0;
      abort_nx = 1'b0;
      unique case (phase)
         PH_OFF: begin
            if (supply_ok) begin
               phase_nx = PH_CLEAR; tmr_load = 1'b1; tmr_val = CLEAR_LD;
            end
         end
         PH_IDLE: begin
            if (take_rcl) begin
               phase_nx = PH_CLEAR; tmr_load = 1'b1; tmr_val = CLEAR_LD;
            end else if (take_sto) begin
               phase_nx = PH_ERASE; tmr_load = 1'b1; tmr_val = ERASE_LD;
            end
         end
         PH_ERASE: begin
            if (!supply_ok) begin
               phase_nx = PH_IDLE; abort_nx = 1'b1;
            end else if (tmr_done) begin
               op_erase = 1'b1;
               phase_nx = PH_PROG; tmr_load = 1'b1; tmr_val = PROG_LD;
            end
         end
         PH_PROG: begin
            if (!supply_ok) begin
               phase_nx = PH_IDLE; abort_nx = 1'b1;
            end else if (tmr_done) begin
               op_prog  = 1'b1;
               phase_nx = PH_IDLE;
            end
         end
         PH_CLEAR: begin
            if (tmr_done) begin
               op_clear = 1'b1;
               phase_nx = PH_COPY; tmr_load = 1'b1; tmr_val = COPY_LD;
            end
         end
         PH_COPY: begin
            if (tmr_done) begin
               op_copy  = 1'b1;
               phase_nx = PH_IDLE;
            end
         end
         default: phase_nx = PH_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase         <= PH_OFF;
         store_aborted <= 1'b0;
      end else begin
         phase         <= phase_nx;
         store_aborted <= abort_nx;
      end
   end

   assign busy = ~idle | take_rcl | take_sto;

   p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && busy) |=> (phase == PH_ERASE || phase == PH_CLEAR));

   p_recall_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CLEAR || (phase == PH_COPY && !tmr_done))
      |=> (phase == PH_CLEAR || phase == PH_COPY));

   p_store_needs_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !supply_ok) |=> (phase != PH_ERASE));

   p_abort_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      store_aborted |=> !store_aborted);

   p_abort_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      store_aborted |-> ($past(!supply_ok) && idle));

endmodule

// File: rtl/nv_cell_arrays.sv
module nv_cell_arrays #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_erase,
   input  logic              op_prog,
   input  logic              op_clear,
   input  logic              op_copy,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] ERASED = '1;

   logic [DATA_W-1:0] sram [DEPTH];
   logic [DATA_W-1:0] shadow [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
      end else if (op_clear) begin
         for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
      end else if (op_copy) begin
         for (int i = 0; i < DEPTH; i++) sram[i] <= shadow[i];
      end else if (host_wr) begin
         sram[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
      end else if (op_erase) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= ERASED;
      end else if (op_prog) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= sram[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (host_rd) rdata <= sram[addr];
   end

   // the shadow array only moves on erase or program
   p_shadow_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_erase && !op_prog) |=> ($stable(shadow[0]) && $stable(shadow[DEPTH-1])));

   p_sram_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_clear && !op_copy && !host_wr) |=> $stable(sram[0]));

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
   import nv_seq_pkg::*;
#(
   parameter int DEPTH           = 16,
   parameter int DATA_W          = 8,
   parameter int STO_ERASE_TICKS = 250000,
   parameter int STO_PROG_TICKS  = 250000,
   parameter int RCL_CLEAR_TICKS = 500,
   parameter int RCL_COPY_TICKS  = 500,
   parameter bit RECALL_FIRST    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     supply_ok,
   input  logic                     store_req,
   input  logic                     recall_req,
   input  logic                     ce_n,
   input  logic                     we_n,
   input  logic                     oe_n,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic                     dq_oe,
   output logic                     busy,
   output logic                     standby,
   output logic                     store_aborted
);

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int MAXT   = max4(STO_ERASE_TICKS, STO_PROG_TICKS,
                                RCL_CLEAR_TICKS, RCL_COPY_TICKS);
   localparam int CW     = $clog2(MAXT + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (STO_ERASE_TICKS < 1 || STO_PROG_TICKS < 1 ||
          RCL_CLEAR_TICKS < 1 || RCL_COPY_TICKS < 1) begin : g_bad_ticks
         $error("every phase needs at least one tick");
      end
   endgenerate

   logic          tmr_load, tmr_done;
   logic [CW-1:0] tmr_val;
   logic          op_erase, op_prog, op_clear, op_copy;
   logic          host_wr, host_rd;
   phase_t        phase;

   nv_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   nv_phase_fsm #(
      .CW              (CW),
      .STO_ERASE_TICKS (STO_ERASE_TICKS),
      .STO_PROG_TICKS  (STO_PROG_TICKS),
      .RCL_CLEAR_TICKS (RCL_CLEAR_TICKS),
      .RCL_COPY_TICKS  (RCL_COPY_TICKS),
      .RECALL_FIRST    (RECALL_FIRST)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok     (supply_ok),
      .store_req     (store_req),
      .recall_req    (recall_req),
      .tmr_done      (tmr_done),
      .tmr_load      (tmr_load),
      .tmr_val       (tmr_val),
      .op_erase      (op_erase),
      .op_prog       (op_prog),
      .op_clear      (op_clear),
      .op_copy       (op_copy),
      .busy          (busy),
      .store_aborted (store_aborted),
      .phase         (phase)
   );

   assign host_wr = ~busy & ~ce_n & ~we_n;
   assign host_rd = ~busy & ~ce_n &  we_n;

   nv_cell_arrays #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_arrays (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_erase (op_erase),
      .op_prog  (op_prog),
      .op_clear (op_clear),
      .op_copy  (op_copy),
      .host_wr  (host_wr),
      .host_rd  (host_rd),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata)
   );

   assign dq_oe   = host_rd & ~oe_n;
   assign standby = ce_n & ~busy;

   p_standby_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (phase == PH_IDLE));

   p_rdata_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(rdata));

   p_hiz_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |-> !dq_oe);

endmodule

// File: tb/sim_nv_xfer_seq.sv
module sim_nv_xfer_seq;

   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int ER    = 6;
   localparam int PR    = 5;
   localparam int CL    = 3;
   localparam int CP    = 4;

   localparam int S_OFF = 0, S_IDLE = 1, S_ERASE = 2, S_PROG = 3, S_CLEAR = 4, S_COPY = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_ok = 1'b0;
   logic          store_req = 1'b0;
   logic          recall_req = 1'b0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [3:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          dq_oe, busy, standby, store_aborted;

   always #10 clk = ~clk;

   nv_xfer_seq #(
      .DEPTH (DEPTH), .DATA_W (DW),
      .STO_ERASE_TICKS (ER), .STO_PROG_TICKS (PR),
      .RCL_CLEAR_TICKS (CL), .RCL_COPY_TICKS (CP),
      .RECALL_FIRST (1'b1)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok),
      .store_req (store_req), .recall_req (recall_req),
      .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n), .addr (addr), .wdata (wdata),
      .rdata (rdata), .dq_oe (dq_oe), .busy (busy), .standby (standby),
      .store_aborted (store_aborted)
   );

   // reference model
   int          m_st = S_OFF;
   int          m_rem = 0;
   logic [DW-1:0] m_sram [DEPTH];
   logic [DW-1:0] m_nv [DEPTH];
   logic [DW-1:0] m_rdata = '0;
   logic          m_abort = 1'b0;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur = "R1";

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_sram[i] = '0;
         m_nv[i]   = '0;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         m_st = S_OFF; m_abort = 1'b0; m_rdata = '0;
         for (int i = 0; i < DEPTH; i++) begin m_sram[i] = '0; m_nv[i] = '0; end
      end else begin
         m_abort = 1'b0;
         case (m_st)
            S_OFF: if (supply_ok) begin m_st = S_CLEAR; m_rem = CL; end
            S_IDLE: begin
               if (recall_req) begin m_st = S_CLEAR; m_rem = CL; end
               else if (store_req && supply_ok) begin m_st = S_ERASE; m_rem = ER; end
               else if (!ce_n) begin
                  if (!we_n) m_sram[addr] = wdata;
                  else       m_rdata = m_sram[addr];
               end
            end
            S_ERASE: begin
               if (!supply_ok) begin m_st = S_IDLE; m_abort = 1'b1; end
               else if (m_rem == 1) begin
                  for (int i = 0; i < DEPTH; i++) m_nv[i] = '1;
                  m_st = S_PROG; m_rem = PR;
               end else m_rem--;
            end
            S_PROG: begin
               if (!supply_ok) begin m_st = S_IDLE; m_abort = 1'b1; end
               else if (m_rem == 1) begin
                  for (int i = 0; i < DEPTH; i++) m_nv[i] = m_sram[i];
                  m_st = S_IDLE;
               end else m_rem--;
            end
            S_CLEAR: begin
               if (m_rem == 1) begin
                  for (int i = 0; i < DEPTH; i++) m_sram[i] = '0;
                  m_st = S_COPY; m_rem = CP;
               end else m_rem--;
            end
            S_COPY: begin
               if (m_rem == 1) begin
                  for (int i = 0; i < DEPTH; i++) m_sram[i] = m_nv[i];
                  m_st = S_IDLE;
               end else m_rem--;
            end
            default: m_st = S_OFF;
         endcase
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur, what, act, exp, $time);
      end
   endtask

   task automatic step();
      logic e_busy, e_oe, e_sb;
      @(negedge clk);
      e_busy = (m_st != S_IDLE) || recall_req || (store_req && supply_ok);
      e_oe   = !e_busy && !ce_n && !oe_n && we_n;
      e_sb   = ce_n && !e_busy;
      chk("busy", int'(busy), int'(e_busy));
      chk("dq_oe", int'(dq_oe), int'(e_oe));
      chk("standby", int'(standby), int'(e_sb));
      chk("store_aborted", int'(store_aborted), int'(m_abort));
      chk("rdata", int'(rdata), int'(m_rdata));
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic host_idle();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic fill(input int seed);
      for (int i = 0; i < DEPTH; i++) begin
         ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
         addr = 4'(i); wdata = 8'(i * 17 + seed);
         step();
      end
      host_idle();
   endtask

   task automatic read_all();
      for (int i = 0; i < DEPTH; i++) begin
         ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 4'(i);
         step();
      end
      host_idle();
      step();
   endtask

   task automatic pulse_store();
      store_req = 1'b1; step(); store_req = 1'b0;
   endtask

   task automatic pulse_recall();
      recall_req = 1'b1; step(); recall_req = 1'b0;
   endtask

   initial begin
      // R1: reset state, then wait for supply
      cur = "R1";
      steps(3);
      rst_n = 1'b1;
      steps(2);
      cur = "R7";                       // write attempt before power-up recall
      ce_n = 1'b0; we_n = 1'b0; addr = 4'd3; wdata = 8'hA5;
      steps(2);
      host_idle();
      cur = "R1";
      supply_ok = 1'b1;
      cur = "R11";
      steps(CL + CP + 2);

      cur = "R10";
      fill(3);
      cur = "R9";
      read_all();

      // R3: store, with host activity dropped meanwhile (R6, R7)
      cur = "R3";
      pulse_store();
      cur = "R6";
      recall_req = 1'b1; step(); recall_req = 1'b0;
      store_req = 1'b1; step(); store_req = 1'b0;
      cur = "R7";
      ce_n = 1'b0; we_n = 1'b0; addr = 4'd5; wdata = 8'h00; step();
      we_n = 1'b1; oe_n = 1'b0; addr = 4'd7; step();
      host_idle();
      cur = "R11";
      steps(ER + PR);
      cur = "R3";
      read_all();

      // R2: overwrite then recall brings back the stored image
      cur = "R2";
      fill(90);
      pulse_recall();
      steps(CL + CP + 1);
      read_all();

      // R4: store refused with low supply, aborts in erase and program
      cur = "R4";
      fill(40);
      supply_ok = 1'b0;
      store_req = 1'b1; step(); store_req = 1'b0;
      steps(2);
      supply_ok = 1'b1;
      pulse_store();
      steps(2);
      supply_ok = 1'b0;                 // abort in erase phase
      steps(3);
      supply_ok = 1'b1;
      read_all();                       // SRAM untouched
      pulse_recall();
      steps(CL + CP + 1);
      read_all();                       // shadow unchanged
      fill(60);
      pulse_store();
      steps(ER + 2);
      supply_ok = 1'b0;                 // abort in program phase
      steps(3);

      // R5: recall with supply low runs through; shadow was erased
      cur = "R5";
      pulse_recall();
      steps(CL + CP + 2);
      supply_ok = 1'b1;
      read_all();

      // R6: both requests together, recall wins
      cur = "R6";
      fill(7);
      store_req = 1'b1; recall_req = 1'b1; step();
      store_req = 1'b0; recall_req = 1'b0;
      steps(CL + CP + 1);
      read_all();

      // R8: standby only when deselected and idle
      cur = "R8";
      ce_n = 1'b1; steps(2);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; steps(2);
      host_idle();
      pulse_store();
      steps(ER + PR + 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule